// File: doc/BRIEF.md
# Packed Eight-Lane Alpha Blend Unit

This block mixes two images a word at a time. Each input word carries eight unsigned 8-bit pixels side by side: one word holds the foreground and one holds the background. A single 8-bit weight applies to all eight lanes. Each lane computes a weighted average of its two pixels in parallel with the others. The weights are normalised by 255 rather than 256. As a result, the largest weight returns the foreground unchanged and a zero weight returns the background unchanged. A weight of 230 gives a result that is roughly nine parts foreground to one part background.

Words enter and leave through valid/ready handshakes. There are two register stages. The first stage forms the per-lane weighted sums plus the rounding offset. The second stage divides by 255, clamps the result and holds it as the output. A valid bit travels with each word. When the output is held and not taken, the whole pipe freezes and the input is refused.

Top module: `pxblend_top`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1 until a word has been accepted.
- R2: Each output lane equals (fg*w + bg*(255-w) + 127) / 255 in integer arithmetic, with fg, bg and w unsigned. This is the nearest integer, and a remainder of 128 or more rounds up.
- R3: A weight of 0 returns each background pixel exactly.
- R4: A weight of 255 (8'hFF) returns each foreground pixel exactly.
- R5: Lane k occupies bits [8k+7:8k] of `fg_pix`, `bg_pix` and `out_pix`, for k = 0 to 7. A lane's result depends only on its own two pixels and the shared weight.
- R6: A word accepted on a clock edge (`in_valid` and `in_ready` both 1) appears on `out_valid`/`out_pix` after the second edge that follows, provided `out_ready` stays 1.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and on the next cycle `out_valid` stays 1 with `out_pix` unchanged.
- R8: Every accepted word is delivered exactly once and in order. No more than two words are in flight at any time.
- R9: Every output lane lies between the smaller and the larger of its two input pixels, inclusive, and never exceeds 8'hFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take an input word this cycle |
| fg_pix | input | 64 | Eight packed foreground pixels |
| bg_pix | input | 64 | Eight packed background pixels |
| weight | input | 8 | Shared foreground weight, 255 = all foreground |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word this cycle |
| out_pix | output | 64 | Eight packed blended pixels |

## Verification
A bad rounding offset or a wrong divide shows up two cycles later as an off-by-one lane value. It is most visible at weights 0 and 255, where the result must match an input exactly. A valid bit that is lost or duplicated in the pipe shows up as a missing, extra or reordered word at the output within two cycles. A stall that leaks shows up on the very next cycle as a changed `out_pix` while `out_ready` is low. Lane wiring faults show up as values that land in the wrong byte when each lane carries different pixels.

// File: rtl/pxblend_pkg.sv
package pxblend_pkg;
  localparam int PX_W    = 8;
  localparam int SUM_W   = 2 * PX_W + 1;
  localparam int MAXV    = (1 << PX_W) - 1;
  localparam int HALF    = (MAXV - 1) / 2;

  typedef logic [PX_W-1:0]  px_t;
  typedef logic [SUM_W-1:0] sum_t;

  // weighted sum of one lane plus rounding offset
  function automatic sum_t blend_sum(input px_t fg, input px_t bg, input px_t w);
    sum_t a, b, wi;
    wi = sum_t'(MAXV) - sum_t'(w);
    a  = sum_t'(fg) * sum_t'(w);
    b  = sum_t'(bg) * wi;
    return a + b + sum_t'(HALF);
  endfunction

  // divide by full-scale value and clamp
  function automatic px_t norm_div(input sum_t s);
    sum_t q;
    q = s / sum_t'(MAXV);
    if (q > sum_t'(MAXV)) return px_t'(MAXV);
    return q[PX_W-1:0];
  endfunction
endpackage

// File: rtl/pxblend_lane_mac.sv
module pxblend_lane_mac
  import pxblend_pkg::*;
(
  input  logic clk,
  input  logic en,
  input  px_t  fg,
  input  px_t  bg,
  input  px_t  w,
  output sum_t sum_q
);
  always_ff @(posedge clk) begin
    if (en) sum_q <= blend_sum(fg, bg, w);
  end
endmodule

// File: rtl/pxblend_lane_norm.sv
module pxblend_lane_norm
  import pxblend_pkg::*;
(
  input  logic clk,
  input  logic en,
  input  sum_t sum_d,
  output px_t  px_q
);
  always_ff @(posedge clk) begin
    if (en) px_q <= norm_div(sum_d);
  end
endmodule

// File: rtl/pxblend_ctrl.sv
module pxblend_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic adv,
  output logic s1_v,
  output logic s2_v
);
  assign adv = out_ready | ~s2_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else if (adv) begin
      s1_v <= in_valid;
      s2_v <= s1_v;
    end
  end
endmodule

// File: rtl/pxblend_top.sv
module pxblend_top
  import pxblend_pkg::*;
#(
  parameter int LANES = 8,
  localparam int WORD_W = LANES * PX_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] fg_pix,
  input  logic [WORD_W-1:0] bg_pix,
  input  logic [PX_W-1:0]   weight,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_pix
);
  logic adv, s1_v, s2_v;
  logic accept, deliver;

  pxblend_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .adv(adv), .s1_v(s1_v), .s2_v(s2_v)
  );

  assign in_ready  = adv;
  assign out_valid = s2_v;
  assign accept    = in_valid & adv;
  assign deliver   = s2_v & out_ready;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    sum_t lane_sum;
    px_t  lane_px;

    pxblend_lane_mac u_mac (
      .clk(clk), .en(adv),
      .fg(fg_pix[k*PX_W +: PX_W]), .bg(bg_pix[k*PX_W +: PX_W]), .w(weight),
      .sum_q(lane_sum)
    );

    pxblend_lane_norm u_norm (
      .clk(clk), .en(adv), .sum_d(lane_sum), .px_q(lane_px)
    );

    assign out_pix[k*PX_W +: PX_W] = lane_px;
  end
endmodule

// File: rtl/pxblend_chk.sv
module pxblend_chk #(
  parameter int WORD_W = 64
)(
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_pix,
  input logic              accept,
  input logic              deliver,
  input logic              s1_v,
  input logic              adv
);
  logic [2:0] inflight;

  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + {2'b0, accept} - {2'b0, deliver};
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) $rose(rst_n) |-> !out_valid && in_ready);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix));

  // R7
  stall_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R6
  stage_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v && adv |=> out_valid);

  // R8
  inflight_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 3'd2);

  // R8
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight != 3'd0);
endmodule

bind pxblend_top pxblend_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_pix(out_pix), .accept(accept), .deliver(deliver),
  .s1_v(s1_v), .adv(adv)
);

// File: tb/pxblend_top_tb_top.sv
module pxblend_top_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [63:0] fg_pix = '0;
  logic [63:0] bg_pix = '0;
  logic [7:0]  weight = '0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [63:0] out_pix;

  always #2 clk = ~clk;

  pxblend_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .fg_pix(fg_pix), .bg_pix(bg_pix), .weight(weight),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  int total = 0, bad = 0, cyc = 0;
  int n_acc = 0, n_del = 0;
  bit done = 0;

  logic [63:0] q_fg[$], q_bg[$];
  logic [7:0]  q_w[$];
  int          q_cyc[$];
  bit          q_lat[$];
  string       q_tag[$];

  bit          d_v = 0, d_r = 1, d_lat = 0;
  logic [63:0] d_fg = '0, d_bg = '0;
  logic [7:0]  d_w = '0;
  string       d_tag = "R2";

  bit          prev_stall = 0;
  logic [63:0] prev_pix = '0;

  function automatic int ref_lane(int f, int b, int a);
    int n, q;
    n = f * a + b * (255 - a);
    q = n / 255;
    if (n % 255 >= 128) q++;
    if (q > 255) q = 255;
    return q;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic step();
    @(negedge clk);
    in_valid  = d_v;
    fg_pix    = d_fg;
    bg_pix    = d_bg;
    weight    = d_w;
    out_ready = d_r;
    #1;
    if (prev_stall) begin
      // R7 hold
      check(out_valid == 1'b1, "R7", "valid held", out_valid, 1);
      check(out_pix == prev_pix, "R7", "pix held", out_pix, prev_pix);
    end
    if (out_valid && !out_ready)
      check(in_ready == 1'b0, "R7", "refuse in stall", in_ready, 0);
    prev_stall = out_valid && !out_ready;
    prev_pix   = out_pix;
    if (in_valid && in_ready) begin
      q_fg.push_back(fg_pix); q_bg.push_back(bg_pix); q_w.push_back(weight);
      q_cyc.push_back(cyc); q_lat.push_back(d_lat); q_tag.push_back(d_tag);
      n_acc++;
    end
    if (out_valid && out_ready) begin
      n_del++;
      if (q_fg.size() == 0) begin
        check(0, "R8", "unexpected word", out_pix, 0);
      end else begin
        logic [63:0] f, b; logic [7:0] w; int c; bit l; string t;
        f = q_fg.pop_front(); b = q_bg.pop_front(); w = q_w.pop_front();
        c = q_cyc.pop_front(); l = q_lat.pop_front(); t = q_tag.pop_front();
        if (l) check(cyc - c == 2, "R6", "latency", cyc - c, 2);
        for (int k = 0; k < 8; k++) begin
          int fe, be, ex, ac, lo, hi;
          fe = int'(f[k*8 +: 8]); be = int'(b[k*8 +: 8]);
          ex = ref_lane(fe, be, int'(w));
          ac = int'(out_pix[k*8 +: 8]);
          check(ac == ex, t, $sformatf("lane %0d w=%0d", k, w), ac, ex);
          lo = (fe < be) ? fe : be; hi = (fe < be) ? be : fe;
          check(ac >= lo && ac <= hi, "R9", $sformatf("range lane %0d", k), ac, lo);
        end
      end
    end
    cyc++;
  endtask

  task automatic send(logic [63:0] f, logic [63:0] b, logic [7:0] w, string t, bit lat);
    d_v = 1; d_fg = f; d_bg = b; d_w = w; d_tag = t; d_lat = lat; d_r = 1;
    step();
    d_v = 0; d_lat = 0;
    repeat (3) step();
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    // R1 reset state
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // R3 weight 0 and R4 weight 255, with R6 latency
    send(rnd64(), rnd64(), 8'd0, "R3", 1);
    send(rnd64(), rnd64(), 8'hFF, "R4", 1);
    send(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 8'd230, "R2", 1);
    send(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 8'd230, "R2", 1);
    // R5 distinct lanes
    send(64'hF0D0_B090_7050_3010, 64'h0718_293A_4B5C_6D7E, 8'd128, "R5", 1);
    send(64'h0000_0000_0000_00FF, 64'hFF00_0000_0000_0000, 8'd77, "R5", 1);
    // R2 rounding edge: remainder exactly 128 and 127
    send(64'h0101_0101_0101_0101, 64'h0, 8'd128, "R2", 1);
    send(64'h0101_0101_0101_0101, 64'h0, 8'd127, "R2", 1);

    // random traffic with stalls (R2, R7, R8)
    for (int i = 0; i < 4000; i++) begin
      int sel;
      d_v  = ($urandom() % 10) < 7;
      d_r  = ($urandom() % 10) < 6;
      d_fg = rnd64(); d_bg = rnd64();
      sel  = $urandom() % 10;
      d_w  = (sel == 0) ? 8'd0 : (sel == 1) ? 8'hFF : 8'($urandom());
      d_tag = (d_w == 0) ? "R3" : (d_w == 8'hFF) ? "R4" : "R2";
      d_lat = 0;
      step();
    end

    // drain, R8
    d_v = 0; d_r = 1;
    repeat (8) step();
    check(q_fg.size() == 0, "R8", "words left in flight", q_fg.size(), 0);
    check(n_acc == n_del, "R8", "accepted vs delivered", n_del, n_acc);
    finish_run();
  end
endmodule